// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port that moves one byte at a time over a single shared data line. The port generates the shift clock itself. Each bit slot lasts a fixed number of system clock cycles. Outside a transfer the shift clock rests high.

Two events start a transfer, and there is no separate start command. Writing a byte into the transmit buffer sends that byte out, least significant bit first, with the data line driven. Clearing the receive-done flag while receive is enabled starts a reception instead. During a reception the line is released and a bit is captured on every rising shift clock.

Each direction has a done flag that rises when its transfer completes. The received byte becomes visible on the byte output in the same cycle that its done flag rises.

Top module: `sync_shift_port`

## Requirements
- R1: While a transfer runs, the shift clock is low for 6 system clocks and high for 6, so rising edges come exactly 12 system clocks apart. Each transfer has exactly 8 rising edges. Between transfers the shift clock is held high.
- R2: A `bufWr` pulse while idle starts a transmission of `bufWrData`, with bit 0 sent first. Each bit is on `dataOut` at least 10 system clocks before its rising shift clock. It stays unchanged for at least 2 system clocks after that edge.
- R3: `txDone` becomes 1 two system clocks after the eighth rising shift clock of a transmission. It stays set until a `txDoneClr` pulse clears it.
- R4: A `rxDoneClr` pulse with `rxEnable`=1 while idle starts a reception. `dataIn` is captured on the system clock edge at which the shift clock rises. The first captured bit becomes bit 0 of the received byte.
- R5: `rxDone` becomes 1 two system clocks after the eighth rising shift clock of a reception. In that same cycle `rxByte` takes the received value. `rxByte` does not change at any other time.
- R6: A `rxDoneClr` pulse with `rxEnable`=0 clears `rxDone` but starts nothing. The shift clock stays high and `rxByte` is unchanged.
- R7: A `bufWr` or `rxDoneClr` pulse during an active transfer does not restart it or change its direction. The transferred byte is not altered.
- R8: `dataOe` is 1 only while a transmission is in progress. It is 0 during a reception and while idle.
- R9: After reset, `shiftClk`=1, `dataOe`=0, `txDone`=0, `rxDone`=0 and `rxByte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufWr | input | 1 | Write strobe for the transmit buffer |
| bufWrData | input | 8 | Byte to transmit |
| rxEnable | input | 1 | Allows a flag clear to start a reception |
| rxDoneClr | input | 1 | Clears the receive-done flag (may start a reception) |
| txDoneClr | input | 1 | Clears the transmit-done flag |
| rxByte | output | 8 | Last received byte |
| txDone | output | 1 | Transmit-done flag |
| rxDone | output | 1 | Receive-done flag |
| shiftClk | output | 1 | Generated shift clock |
| dataOut | output | 1 | Serial data to drive onto the line |
| dataIn | input | 1 | Serial data read from the line |
| dataOe | output | 1 | Drive enable for the data line |

## Verification
The bench builds the port with its default parameters: an 8-bit word, a 12-cycle bit slot, the rising edge at slot phase 10, and a 6-cycle low phase. With these values every edge position can be counted against the 10-cycle setup and the 2-cycle hold.

It sends and receives random bytes and the all-zeros, all-ones and alternating patterns. Some of these transfers carry start requests injected partway through. This reaches the late-flag timing, the moment the received byte is published, and the ignored-start paths.

// File: rtl/sync_shift_port_pkg.sv
package sync_shift_port_pkg;
  typedef struct packed {
    logic load;      // capture transmit byte into shift register
    logic shiftOut;  // advance to next transmit bit
    logic sampleIn;  // capture line bit at shift clock rise
    logic finishRx;  // publish received byte
  } spStrobeT;
endpackage

// File: rtl/sync_shift_port_ctrl.sv
module sync_shift_port_ctrl
  import sync_shift_port_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV     = 12,
  parameter int RISE    = 10,
  parameter int LOW_LEN = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bufWr,
  input  logic     rxEnable,
  input  logic     rxDoneClr,
  input  logic     txDoneClr,
  output spStrobeT strobes,
  output logic     txDone,
  output logic     rxDone,
  output logic     shiftClk,
  output logic     dataOe
);
  localparam int PH_W  = $clog2(DIV);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(RISE - 1);
  localparam logic [PH_W-1:0]  PH_RISE   = PH_W'(RISE);
  localparam logic [PH_W-1:0]  PH_LOW    = PH_W'(RISE - LOW_LEN);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(DATA_W - 1);

  logic             active;
  logic             isTx;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] bitCnt;
  logic             txStart, rxStart, lastPhase, lastBit, finish;

  assign txStart   = bufWr && !active;
  assign rxStart   = rxDoneClr && rxEnable && !active && !bufWr;
  assign lastPhase = (phase == PH_LAST);
  assign lastBit   = (bitCnt == BIT_LAST);
  assign finish    = active && lastPhase && lastBit;

  always_comb begin
    strobes          = '0;
    strobes.load     = txStart;
    strobes.shiftOut = active && isTx && lastPhase && !lastBit;
    strobes.sampleIn = active && !isTx && (phase == PH_SAMPLE);
    strobes.finishRx = finish && !isTx;
  end

  assign shiftClk = !(active && (phase >= PH_LOW) && (phase < PH_RISE));
  assign dataOe   = active && isTx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      isTx   <= 1'b0;
      phase  <= '0;
      bitCnt <= '0;
    end else if (!active) begin
      if (txStart || rxStart) begin
        active <= 1'b1;
        isTx   <= txStart;
        phase  <= '0;
        bitCnt <= '0;
      end
    end else if (lastPhase) begin
      phase <= '0;
      if (lastBit) active <= 1'b0;
      else         bitCnt <= bitCnt + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txDone <= 1'b0;
      rxDone <= 1'b0;
    end else begin
      if (finish && isTx)  txDone <= 1'b1;
      else if (txDoneClr)  txDone <= 1'b0;
      if (finish && !isTx) rxDone <= 1'b1;
      else if (rxDoneClr)  rxDone <= 1'b0;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phase <= PH_LAST);  // R1
  AST_RISE_AT_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (active && $rose(shiftClk)) |-> (phase == PH_RISE));  // R1
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (active && !finish) |=> (active && $stable(isTx)));  // R7
  AST_TXDONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !txDoneClr) |=> txDone);  // R3
endmodule

// File: rtl/sync_shift_port_dp.sv
module sync_shift_port_dp
  import sync_shift_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobeT          strobes,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              dataIn,
  output logic              dataOut,
  output logic [DATA_W-1:0] rxByte
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.load) begin
      shiftReg <= bufWrData;
    end else if (strobes.shiftOut) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end else if (strobes.sampleIn) begin
      shiftReg <= {dataIn, shiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rxByte <= '0;
    else if (strobes.finishRx) rxByte <= shiftReg;
  end

  assign dataOut = shiftReg[0];

  AST_RXBYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finishRx |=> $stable(rxByte));  // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.shiftOut, strobes.sampleIn}));  // R7
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import sync_shift_port_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV     = 12,
  parameter int RISE    = 10,
  parameter int LOW_LEN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              rxEnable,
  input  logic              rxDoneClr,
  input  logic              txDoneClr,
  output logic [DATA_W-1:0] rxByte,
  output logic              txDone,
  output logic              rxDone,
  output logic              shiftClk,
  output logic              dataOut,
  input  logic              dataIn,
  output logic              dataOe
);
  spStrobeT strobes;

  sync_shift_port_ctrl #(
    .DATA_W(DATA_W), .DIV(DIV), .RISE(RISE), .LOW_LEN(LOW_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bufWr(bufWr), .rxEnable(rxEnable),
    .rxDoneClr(rxDoneClr), .txDoneClr(txDoneClr), .strobes(strobes),
    .txDone(txDone), .rxDone(rxDone), .shiftClk(shiftClk), .dataOe(dataOe)
  );

  sync_shift_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bufWrData(bufWrData),
    .dataIn(dataIn), .dataOut(dataOut), .rxByte(rxByte)
  );
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bufWr = 1'b0;
  logic [7:0] bufWrData = '0;
  logic       rxEnable = 1'b0;
  logic       rxDoneClr = 1'b0;
  logic       txDoneClr = 1'b0;
  logic [7:0] rxByte;
  logic       txDone, rxDone, shiftClk, dataOut, dataOe;
  logic       dataIn = 1'b0;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sync_shift_port u_dut (
    .clk(clk), .rstN(rstN), .bufWr(bufWr), .bufWrData(bufWrData),
    .rxEnable(rxEnable), .rxDoneClr(rxDoneClr), .txDoneClr(txDoneClr),
    .rxByte(rxByte), .txDone(txDone), .rxDone(rxDone), .shiftClk(shiftClk),
    .dataOut(dataOut), .dataIn(dataIn), .dataOe(dataOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected bit k of a byte, bit 0 first on the line
  function automatic logic lineBit(input logic [7:0] b, input int k);
    return (k < 8) ? b[k] : 1'b0;
  endfunction

  task automatic doTx(input logic [7:0] b, input bit inject);
    int n = 0, rises = 0, sinceRise = 99, sinceChg = 0, lowCnt = 0;
    bit oeBad = 0, holdBad = 0, setupBad = 0, bitBad = 0, perBad = 0, lowBad = 0;
    logic prevClk, prevOut;
    logic [7:0] oldRx = rxByte;
    @(negedge clk); bufWr = 1; bufWrData = b;
    @(negedge clk); bufWr = 0;
    prevClk = shiftClk; prevOut = dataOut;
    while (!txDone && n < 150) begin
      if (!dataOe) oeBad = 1;
      if (inject && n == 20) begin bufWr = 1; bufWrData = ~b; rxEnable = 1; rxDoneClr = 1; end
      else begin bufWr = 0; rxDoneClr = 0; end
      @(negedge clk); n++; sinceRise++; sinceChg++;
      if (dataOut !== prevOut) begin
        if (rises > 0 && sinceRise < 2) holdBad = 1;
        sinceChg = 0;
      end
      if (!shiftClk) lowCnt++;
      if (shiftClk && !prevClk) begin
        if (dataOut !== lineBit(b, rises)) bitBad = 1;
        if (sinceChg < 10) setupBad = 1;
        if (rises > 0 && sinceRise != 12) perBad = 1;
        if (lowCnt != 6) lowBad = 1;
        lowCnt = 0; rises++; sinceRise = 0;
      end
      prevClk = shiftClk; prevOut = dataOut;
    end
    bufWr = 0; rxDoneClr = 0;
    chk(!bitBad, "R2 bit order", bitBad, 0);
    chk(!setupBad, "R2 setup", setupBad, 0);
    chk(!holdBad, "R2 hold", holdBad, 0);
    chk(!perBad && !lowBad, "R1 period/low", {perBad, lowBad}, 0);
    chk(rises == 8, "R1 rise count", rises, 8);
    chk(txDone && sinceRise == 2, "R3 flag timing", sinceRise, 2);
    chk(!oeBad, "R8 oe during tx", oeBad, 0);
    chk(!dataOe && shiftClk, "R8 R1 idle after tx", {dataOe, shiftClk}, 1);
    if (inject) chk(rxByte == oldRx, "R7 no rx started", rxByte, oldRx);
    @(negedge clk); txDoneClr = 1;
    @(negedge clk); txDoneClr = 0;
    chk(!txDone, "R3 clear", txDone, 0);
  endtask

  task automatic doRx(input logic [7:0] b, input bit inject);
    int n = 0, rises = 0, sinceRise = 99;
    bit oeBad = 0, earlyBad = 0, perBad = 0;
    logic prevClk;
    logic [7:0] oldRx = rxByte;
    dataIn = b[0];
    @(negedge clk); rxEnable = 1; rxDoneClr = 1;
    @(negedge clk); rxDoneClr = 0;
    prevClk = shiftClk;
    while (!rxDone && n < 150) begin
      if (inject && n == 30) begin bufWr = 1; bufWrData = 8'h3c; end
      else bufWr = 0;
      @(negedge clk); n++; sinceRise++;
      if (dataOe) oeBad = 1;
      if (!rxDone && rxByte !== oldRx) earlyBad = 1;
      if (shiftClk && !prevClk) begin
        if (rises > 0 && sinceRise != 12) perBad = 1;
        rises++; sinceRise = 0;
        dataIn = lineBit(b, rises);
      end
      prevClk = shiftClk;
    end
    bufWr = 0;
    chk(rxByte == b, "R4 received byte", rxByte, b);
    chk(rxDone && sinceRise == 2, "R5 flag timing", sinceRise, 2);
    chk(!earlyBad, "R5 byte stable during rx", earlyBad, 0);
    chk(rises == 8 && !perBad, "R1 rx clock", rises, 8);
    chk(!oeBad, "R8 released during rx", oeBad, 0);
    if (inject) chk(!txDone, "R7 no tx started", txDone, 0);
  endtask

  task automatic doRxDisabled();
    bit fell = 0;
    logic [7:0] oldRx = rxByte;
    @(negedge clk); rxEnable = 0; rxDoneClr = 1;
    @(negedge clk); rxDoneClr = 0;
    chk(!rxDone, "R6 flag cleared", rxDone, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!shiftClk || dataOe) fell = 1;
    end
    chk(!fell, "R6 no transfer", fell, 0);
    chk(rxByte == oldRx && !rxDone, "R6 byte unchanged", rxByte, oldRx);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3a));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(shiftClk && !dataOe, "R9 idle lines", {shiftClk, dataOe}, 2);
    chk(!txDone && !rxDone && rxByte == 0, "R9 flags and byte", {txDone, rxDone, rxByte}, 0);
    doTx(8'h00, 0);
    doTx(8'hff, 0);
    doTx(8'ha5, 1);
    for (int i = 0; i < 5; i++) doTx(8'($urandom), i[0]);
    doRx(8'h5a, 0);
    doRx(8'hff, 1);
    doRx(8'h01, 0);
    doRxDisabled();
    for (int i = 0; i < 5; i++) doRx(8'($urandom), i[0]);
    doRxDisabled();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule